// File: doc/BRIEF.md
# RTC Control Register with Shared Interrupt / Square-Wave Pin

This block holds the 8-bit control byte of a real-time clock and drives one active-low pin that is shared between a programmable square wave and a level-held alarm interrupt. A register-write port loads the byte and a read port returns it continuously. Two alarm-match pulses set sticky flags, and a per-flag clear request removes them. The pin has a data output and an output enable, so the pad can be open-drain or floated.

The square wave is produced by dividing a free-running 8.192 kHz reference level. The reference is sampled in the system clock domain, and its rising edges are counted. A primary-power-good input selects battery behaviour. On battery, the wave is passed out only when the battery-wave bit allows it, and the timebase stops when the oscillator-off bit is set.

The pin is steered by a three-state machine.
- `PIN_IRQ`: interrupt mode. The pin is driven low while any enabled flag is set.
- `PIN_WAVE`: the pin carries the square wave.
- `PIN_FLOAT`: the pin is released.

The reset state is `PIN_IRQ`. On every cycle the machine takes one of three transitions, from any state:
- to `PIN_IRQ` when the interrupt-select bit is 1;
- to `PIN_WAVE` when that bit is 0 and either main power is good or the battery-wave bit is 1;
- to `PIN_FLOAT` otherwise.

Top module: `rtc_ctl_pin`

## Requirements
- R1: `rd_data` returns the last byte written through `wr_en`/`wr_data`, all eight bits. The bit layout is: bit 7 oscillator-off, bit 6 battery-wave enable, bit 5 convert request (stored only), bits 4:3 rate, bit 2 interrupt-select, bit 1 alarm-2 enable, bit 0 alarm-1 enable.
- R2: After reset, the register reads 0x1C and both flags are 0. The pin is then in interrupt mode and released high (`pin_oe`=1, `pin_n`=1).
- R3: The rate field sets the square-wave period, counted in reference periods: 00 gives SLOW_DIV, 01 gives MID_DIV, 10 gives FAST_DIV, and 11 follows the reference itself. Every rate has a 50% duty cycle.
- R4: With interrupt-select at 0 and main power good, `pin_oe` is 1 and `pin_n` carries the square wave.
- R5: A pulse on `alm1_hit` sets `flags[0]`, and a pulse on `alm2_hit` sets `flags[1]`, whatever the interrupt-select bit. A flag then holds until its `flag_clr` bit is pulsed. A set and a clear in the same cycle leave the flag set.
- R6: With interrupt-select at 1, `pin_oe` is 1 and `pin_n` is low exactly when some flag is set together with its own enable bit. In wave mode, flags never reach the pin.
- R7: On battery (`pwr_good`=0) with interrupt-select at 0, the wave is output if the battery-wave bit is 1. If that bit is 0, the pin floats (`pin_oe`=0, `pin_n`=1).
- R8: With oscillator-off at 1 on battery, the square wave freezes at its level. On main power the bit has no effect.
- R9: A write that changes the rate field clears the divider. The wave is low in the next cycle, and the first high phase that follows has the full length for the new rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, power-on |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register value |
| ref_8k | input | 1 | 8.192 kHz reference level, synchronous to clk |
| pwr_good | input | 1 | 1 = main power, 0 = battery |
| alm1_hit | input | 1 | Alarm-1 match pulse |
| alm2_hit | input | 1 | Alarm-2 match pulse |
| flag_clr | input | 2 | Flag clear request, bit 0 alarm 1, bit 1 alarm 2 |
| flags | output | 2 | Sticky alarm flags, bit 0 alarm 1, bit 1 alarm 2 |
| pin_n | output | 1 | Pin data, active-low interrupt or square wave |
| pin_oe | output | 1 | Pin output enable, 0 = high impedance |

## Verification
The bench builds the block with SLOW_DIV set to 64 and keeps MID_DIV at 8 and FAST_DIV at 2. It drives a reference with an 8-cycle period, so the slowest rate has a 512-cycle period. This lets the bench measure complete high and low phases at all four rates, including the first phase after a rate change. At the default SLOW_DIV of 8192, a single 1 Hz period would take most of the cycle budget.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;

    localparam int NUM_ALARMS = 2;
    localparam logic [7:0] CTRL_RESET = 8'h1C;

    // Field order follows the bit positions software decodes (bit 7 first).
    typedef struct packed {
        logic       osc_off;
        logic       bat_wave;
        logic       conv_req;
        logic [1:0] rate;
        logic       irq_sel;
        logic       alm2_en;
        logic       alm1_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_MID  = 2'b01,
        RATE_FAST = 2'b10,
        RATE_REF  = 2'b11
    } rate_t;

    typedef enum logic [1:0] {
        PIN_IRQ   = 2'b00,
        PIN_WAVE  = 2'b01,
        PIN_FLOAT = 2'b10
    } pin_mode_t;

endpackage

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
    import rtc_ctl_pkg::*;
#(
    parameter int NUM_FLAGS = NUM_ALARMS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    input  logic [NUM_FLAGS-1:0] alm_hit,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    output ctrl_t                ctrl,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 div_clr
);

    ctrl_t wr_view;
    assign wr_view = ctrl_t'(wr_data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= ctrl_t'(CTRL_RESET);
        end else if (wr_en) begin
            ctrl <= wr_view;
        end
    end

    // A rate change restarts the divider on the same edge the field updates.
    assign div_clr = wr_en && (wr_view.rate != ctrl.rate);

    // Sticky flags: a set wins over a clear in the same cycle.
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (alm_hit[i]) begin
                flags[i] <= 1'b1;
            end else if (flag_clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rtc_wave_div.sv
module rtc_wave_div
    import rtc_ctl_pkg::*;
#(
    parameter int SLOW_DIV = 8192,
    parameter int MID_DIV  = 8,
    parameter int FAST_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] rate,
    output logic       wave
);

    localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] HALF_SLOW = CW'(SLOW_DIV / 2);
    localparam logic [CW-1:0] HALF_MID  = CW'(MID_DIV / 2);
    localparam logic [CW-1:0] HALF_FAST = CW'(FAST_DIV / 2);

    logic          ref_d;
    logic          rise;
    logic [CW-1:0] cnt;
    logic [CW-1:0] half;
    logic          direct;

    assign rise = ref_in && !ref_d;

    always_comb begin
        direct = 1'b0;
        half   = HALF_FAST;
        unique case (rate_t'(rate))
            RATE_SLOW: half = HALF_SLOW;
            RATE_MID:  half = HALF_MID;
            RATE_FAST: half = HALF_FAST;
            RATE_REF:  direct = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_d <= 1'b0;
            cnt   <= '0;
            wave  <= 1'b0;
        end else begin
            ref_d <= ref_in;
            if (clr) begin
                cnt  <= '0;
                wave <= 1'b0;
            end else if (run) begin
                if (direct) begin
                    wave <= ref_in;
                end else if (rise) begin
                    if (cnt == half - 1'b1) begin
                        cnt  <= '0;
                        wave <= !wave;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtc_pin_fsm.sv
module rtc_pin_fsm
    import rtc_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_sel,
    input  logic bat_wave,
    input  logic pwr_good,
    input  logic irq_req,
    input  logic wave,
    output logic pin_n,
    output logic pin_oe
);

    pin_mode_t state;
    pin_mode_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PIN_IRQ, PIN_WAVE, PIN_FLOAT: begin
                if (irq_sel) begin
                    state_nx = PIN_IRQ;
                end else if (pwr_good || bat_wave) begin
                    state_nx = PIN_WAVE;
                end else begin
                    state_nx = PIN_FLOAT;
                end
            end
            default: state_nx = PIN_IRQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PIN_IRQ;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        pin_n  = 1'b1;
        pin_oe = 1'b1;
        unique case (state)
            PIN_IRQ:   pin_n = !irq_req;
            PIN_WAVE:  pin_n = wave;
            PIN_FLOAT: pin_oe = 1'b0;
            default:   pin_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/rtc_ctl_pin.sv
module rtc_ctl_pin
    import rtc_ctl_pkg::*;
#(
    parameter int SLOW_DIV = 8192,
    parameter int MID_DIV  = 8,
    parameter int FAST_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       ref_8k,
    input  logic       pwr_good,
    input  logic       alm1_hit,
    input  logic       alm2_hit,
    input  logic [1:0] flag_clr,
    output logic [1:0] flags,
    output logic       pin_n,
    output logic       pin_oe
);

    ctrl_t ctrl;
    logic  div_clr;
    logic  wave;
    logic  irq_req;
    logic  run;

    rtc_ctl_regs #(.NUM_FLAGS(NUM_ALARMS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .alm_hit  ({alm2_hit, alm1_hit}),
        .flag_clr (flag_clr),
        .ctrl     (ctrl),
        .flags    (flags),
        .div_clr  (div_clr)
    );

    // The timebase halts only when the oscillator-off bit meets battery power.
    assign run = pwr_good || !ctrl.osc_off;

    rtc_wave_div #(
        .SLOW_DIV (SLOW_DIV),
        .MID_DIV  (MID_DIV),
        .FAST_DIV (FAST_DIV)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_8k),
        .run    (run),
        .clr    (div_clr),
        .rate   (ctrl.rate),
        .wave   (wave)
    );

    assign irq_req = |(flags & {ctrl.alm2_en, ctrl.alm1_en});

    rtc_pin_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_sel  (ctrl.irq_sel),
        .bat_wave (ctrl.bat_wave),
        .pwr_good (pwr_good),
        .irq_req  (irq_req),
        .wave     (wave),
        .pin_n    (pin_n),
        .pin_oe   (pin_oe)
    );

    assign rd_data = ctrl;

endmodule

// File: rtl/rtc_ctl_pin_chk.sv
module rtc_ctl_pin_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       pwr_good,
    input logic       alm1_hit,
    input logic       alm2_hit,
    input logic [1:0] flag_clr,
    input logic [1:0] flags,
    input logic       pin_n,
    input logic       pin_oe
);

    // R1
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    // R2
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == 8'h1C && flags == 2'b00));

    // R5
    alarm1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm1_hit |=> flags[0]);

    // R5
    alarm2_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm2_hit |=> flags[1]);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !flag_clr[0]) |=> flags[0]);

    // R6
    irq_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2] && $past(rd_data[2]) && rd_data[0] && flags[0]) |-> (!pin_n && pin_oe));

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2] && $past(rd_data[2]) && rd_data[1:0] == 2'b00) |-> pin_n);

    // R4
    wave_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[2] && !$past(rd_data[2]) && pwr_good && $past(pwr_good)) |-> pin_oe);

    // R7
    float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2] == 1'b0 && rd_data[6] == 1'b0 && !pwr_good &&
         $past(rd_data[2]) == 1'b0 && $past(rd_data[6]) == 1'b0 && !$past(pwr_good))
        |-> (!pin_oe && pin_n));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_data[7]) && !$past(pwr_good) && !$past(rd_data[2]) && $past(rd_data[6]) &&
         $past(rd_data, 2) == $past(rd_data) && $past(pwr_good, 2) == $past(pwr_good) &&
         !$past(wr_en)) |-> $stable(pin_n));

    // R9
    rate_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[4:3] != rd_data[4:3] && !rd_data[2] && pwr_good) |=> !pin_n);

    // R7
    float_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> pin_n);

endmodule

bind rtc_ctl_pin rtc_ctl_pin_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .pwr_good (pwr_good),
    .alm1_hit (alm1_hit),
    .alm2_hit (alm2_hit),
    .flag_clr (flag_clr),
    .flags    (flags),
    .pin_n    (pin_n),
    .pin_oe   (pin_oe)
);

// File: tb/rtc_ctl_pin_test.sv
`timescale 1ns/1ps
module rtc_ctl_pin_test;

    localparam int SLOW = 64;
    localparam int REF_HALF = 4;  // reference half period in clk cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ref_8k = 1'b0;
    logic       pwr_good = 1'b1;
    logic       alm1_hit = 1'b0;
    logic       alm2_hit = 1'b0;
    logic [1:0] flag_clr = 2'b00;
    logic [1:0] flags;
    logic       pin_n;
    logic       pin_oe;

    int vectors = 0;
    int errs = 0;

    always #2 clk = ~clk;

    rtc_ctl_pin #(.SLOW_DIV(SLOW), .MID_DIV(8), .FAST_DIV(2)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .ref_8k   (ref_8k),
        .pwr_good (pwr_good),
        .alm1_hit (alm1_hit),
        .alm2_hit (alm2_hit),
        .flag_clr (flag_clr),
        .flags    (flags),
        .pin_n    (pin_n),
        .pin_oe   (pin_oe)
    );

    initial begin
        forever begin
            repeat (REF_HALF) @(negedge clk);
            ref_8k = ~ref_8k;
        end
    end

    initial begin
        #(200000 * 4);
        errs++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic a1, input logic a2, input logic [1:0] c);
        @(negedge clk);
        alm1_hit = a1;
        alm2_hit = a2;
        flag_clr = c;
        @(negedge clk);
        alm1_hit = 1'b0;
        alm2_hit = 1'b0;
        flag_clr = 2'b00;
    endtask

    task automatic measure(output int hi, output int lo);
        int guard = 0;
        hi = 0;
        lo = 0;
        while (pin_n !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (pin_n !== 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
        while (pin_n === 1'b1 && guard < 4000) begin hi++; @(negedge clk); guard++; end
        while (pin_n === 1'b0 && guard < 4000) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic t_reset();
        check("R2", "register after reset", rd_data, 8'h1C);
        check("R2", "flags after reset", flags, 2'b00);
        check("R2", "pin_oe after reset", pin_oe, 1'b1);
        check("R2", "pin_n after reset", pin_n, 1'b1);
    endtask

    task automatic t_readback();
        wr(8'hA5);
        check("R1", "readback A5", rd_data, 8'hA5);
        wr(8'h5A);
        check("R1", "readback 5A", rd_data, 8'h5A);
    endtask

    task automatic t_flags();
        int hi, lo;
        wr(8'h04);                       // interrupt mode, no enables
        pulse(1'b1, 1'b0, 2'b00);
        check("R5", "alarm1 sets flag", flags, 2'b01);
        idle(1);
        check("R6", "disabled flag keeps pin high", pin_n, 1'b1);
        wr(8'h05);                       // enable alarm 1
        idle(1);
        check("R6", "enabled flag drives pin low", pin_n, 1'b0);
        check("R6", "pin driven in irq mode", pin_oe, 1'b1);
        idle(5);
        check("R5", "flag held", flags, 2'b01);
        pulse(1'b0, 1'b0, 2'b01);
        check("R5", "flag cleared", flags, 2'b00);
        check("R6", "pin released after clear", pin_n, 1'b1);
        wr(8'h1B);                       // wave mode, rate 11, both enables
        pulse(1'b0, 1'b1, 2'b00);
        check("R5", "alarm2 sets flag in wave mode", flags, 2'b10);
        pulse(1'b1, 1'b0, 2'b01);
        check("R5", "set wins over clear", flags, 2'b11);
        measure(hi, lo);
        check("R6", "flags do not reach pin in wave mode", hi, 32'(REF_HALF));
        pulse(1'b0, 1'b0, 2'b11);
        check("R5", "both flags cleared", flags, 2'b00);
    endtask

    task automatic t_rates();
        int hi, lo;
        int exp_half [4];
        exp_half[0] = (SLOW / 2) * 2 * REF_HALF;
        exp_half[1] = (8 / 2) * 2 * REF_HALF;
        exp_half[2] = (2 / 2) * 2 * REF_HALF;
        exp_half[3] = REF_HALF;
        pwr_good = 1'b1;
        for (int r = 0; r < 4; r++) begin
            wr({3'b000, 2'(r), 3'b000});
            idle(1);
            check("R4", "pin driven in wave mode", pin_oe, 1'b1);
            measure(hi, lo);
            check("R3", $sformatf("high phase rate %0d", r), hi, exp_half[r]);
            check("R3", $sformatf("low phase rate %0d", r), lo, exp_half[r]);
        end
    endtask

    task automatic t_restart();
        int hi, lo;
        int guard = 0;
        wr(8'h10);                       // rate 10
        idle(2);
        while (pin_n !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
        wr(8'h08);                       // rate 01 while the wave is high
        check("R9", "wave cleared after rate change", pin_n, 1'b0);
        measure(hi, lo);
        check("R9", "first high phase full length", hi, 32'(4 * 2 * REF_HALF));
    endtask

    task automatic t_battery();
        int hi, lo;
        wr(8'h00);
        pwr_good = 1'b0;
        idle(2);
        check("R7", "pin floats on battery", pin_oe, 1'b0);
        check("R7", "floating pin data high", pin_n, 1'b1);
        wr(8'h58);                       // battery wave enable, rate 11
        idle(1);
        check("R7", "pin driven with battery wave", pin_oe, 1'b1);
        measure(hi, lo);
        check("R7", "battery wave high phase", hi, 32'(REF_HALF));
    endtask

    task automatic t_freeze();
        int hi, lo;
        int changes = 0;
        logic last;
        pwr_good = 1'b0;
        wr(8'hD8);                       // osc off, battery wave, rate 11
        idle(2);
        last = pin_n;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pin_n !== last) changes++;
            last = pin_n;
        end
        check("R8", "wave frozen on battery", changes, 0);
        pwr_good = 1'b1;
        idle(2);
        measure(hi, lo);
        check("R8", "osc off ignored on main power", hi, 32'(REF_HALF));
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_readback();
        t_flags();
        t_rates();
        t_restart();
        t_battery();
        t_freeze();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule